// File: doc/BRIEF.md
# Subroutine Call and Return Bus Sequencer

This block steps an 8-bit processor core through its two subroutine instructions, one bus cycle per clock. The two instructions are the absolute-target call and the return. The block holds the 16-bit program counter, the 8-bit stack pointer, a one-byte data latch and one internal holding register. In every cycle it presents exactly one memory access: a 16-bit address, a read/write direction and, for writes, a data byte. Memory answers reads combinationally in the same cycle.

A one-cycle `start_i` pulse in the idle state begins an instruction in the next cycle. Cycle 1 fetches the opcode from the program counter. The block then runs the call or the return. For any other opcode it finishes at once. `done_o` pulses in the final cycle of each instruction, and the new register values become visible in the following cycle.

The stack lives in memory page one, which is a parameter. During the call, the low target byte is parked in the stack-pointer register. The stack pointer is decremented in the holding register, and the two are swapped back in the last cycle.

Top module: `callret_seq`

## Requirements
- R1: While reset is asserted, and in the first idle cycles after it, `bus_rd_o` is 1, `done_o` is 0, `pc_o` equals RESET_PC, `sp_o` equals RESET_SP and `bus_addr_o` equals `pc_o`. Asserting reset in the middle of an instruction forces this state at once, without waiting for a clock.
- R2: The cycle after `start_i` is seen in idle is a read at PC, and PC then increments. If the byte read is neither the call code 8'h20 nor the return code 8'h60, `done_o` is 1 in that same cycle and the block returns to idle.
- R3: Call cycle 2 reads the low target byte at PC and increments PC again. Call cycle 3 is a read at {8'h01, S} whose data is not used.
- R4: Call cycles 4 and 5 are writes. Cycle 4 writes PC[15:8] to {8'h01, S}. Cycle 5 writes PC[7:0] to {8'h01, S-1}. `bus_wdata_o` is valid in the same cycle that `bus_rd_o` is 0.
- R5: The 16-bit value pushed by a call equals the call's own address plus two.
- R6: Call cycle 6 reads the high target byte at the call address plus two, with `done_o` high. After it, `pc_o` holds the target and `sp_o` holds the original S minus two.
- R7: A return takes six reads: the opcode at PC, a dummy read at PC+1, a dummy read at {8'h01, S}, the low byte at {8'h01, S+1}, the high byte at {8'h01, S+2}, and a dummy read at the pulled address. `done_o` is high in the last of these.
- R8: After a return, `pc_o` equals the pulled address plus one and `sp_o` equals the original S plus two.
- R9: All stack-pointer arithmetic wraps modulo 256 inside page one. For example, a call with S=8'h00 writes to 16'h0100 and then 16'h01FF, and leaves S=8'hFE.
- R10: `start_i` has no effect while an instruction is in progress.
- R11: `bus_rd_o` is 0 only in the two push cycles of a call, and `done_o` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an instruction (sampled in idle only) |
| bus_rdata_i | input | 8 | Read data from memory, valid in the same cycle |
| bus_addr_o | output | 16 | Memory address of this cycle |
| bus_rd_o | output | 1 | 1 = read, 0 = write |
| bus_wdata_o | output | 8 | Write data, valid when bus_rd_o is 0 |
| done_o | output | 1 | High in the last cycle of an instruction |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack-pointer register |

## Verification
The main sequence runs a nested pair: an outer call with the stack pointer two above the bottom of the page, then an inner call that starts at 8'h00 and so pushes across the page wrap, then the two returns, then an unsupported opcode. The two calls use different targets and different return addresses, so a byte swap on the push, or a push that is off by one from the call address, shows up as a wrong stored value or a wrong final PC. The return that pulls across 8'hFF to 8'h00 separates correct modulo-256 increments from increments that carry into the page byte. Directed cases hold `start_i` high through a whole call, to show that busy-state starts are dropped, and drop reset in the middle of a push, to show that the asynchronous clear takes effect at once.

// File: rtl/callret_pkg.sv
package callret_pkg;

  // One value per bus cycle of the supported instructions
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,    // cycle 1, common opcode fetch
    ST_C_LO,     // call: low target byte
    ST_C_STK,    // call: dummy stack read, park low byte in S
    ST_C_PSH_H,  // call: push PC high
    ST_C_PSH_L,  // call: push PC low
    ST_C_HI,     // call: high target byte, final swap
    ST_R_DUM,    // return: dummy read at PC
    ST_R_STK,    // return: dummy stack read
    ST_R_LO,     // return: pull low byte
    ST_R_HI,     // return: pull high byte
    ST_R_END     // return: dummy read at pulled address, PC+1
  } step_t;

endpackage

// File: rtl/callret_rst_sync.sv
module callret_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/callret_ctrl.sv
module callret_ctrl
  import callret_pkg::*;
#(
  parameter int unsigned          DATA_W   = 8,
  parameter logic [DATA_W-1:0]    CALL_OPC = 8'h20,
  parameter logic [DATA_W-1:0]    RET_OPC  = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] opcode_i,
  output step_t             step_o,
  output logic              done_o
);

  step_t step_q, step_d;
  logic  is_call, is_ret;

  assign is_call = (opcode_i == CALL_OPC);
  assign is_ret  = (opcode_i == RET_OPC);

  always_comb begin
    step_d = step_q;
    done_o = 1'b0;
    unique case (step_q)
      ST_IDLE:    if (start_i) step_d = ST_FETCH;
      ST_FETCH: begin
        if (is_call) begin
          step_d = ST_C_LO;
        end else if (is_ret) begin
          step_d = ST_R_DUM;
        end else begin
          step_d = ST_IDLE;
          done_o = 1'b1;
        end
      end
      ST_C_LO:    step_d = ST_C_STK;
      ST_C_STK:   step_d = ST_C_PSH_H;
      ST_C_PSH_H: step_d = ST_C_PSH_L;
      ST_C_PSH_L: step_d = ST_C_HI;
      ST_C_HI: begin
        step_d = ST_IDLE;
        done_o = 1'b1;
      end
      ST_R_DUM:   step_d = ST_R_STK;
      ST_R_STK:   step_d = ST_R_LO;
      ST_R_LO:    step_d = ST_R_HI;
      ST_R_HI:    step_d = ST_R_END;
      ST_R_END: begin
        step_d = ST_IDLE;
        done_o = 1'b1;
      end
      default:    step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
    end else begin
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/callret_dpath.sv
module callret_dpath
  import callret_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 16,
  parameter int unsigned          DATA_W     = 8,
  parameter logic [DATA_W-1:0]    STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0]    RESET_PC   = 16'h0000,
  parameter logic [DATA_W-1:0]    RESET_SP   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             step_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] sp_o
);

  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
  localparam logic [DATA_W-1:0] SP_ONE = DATA_W'(1);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] sp_q, sp_d, hold_q, hold_d, dlat_q, dlat_d;
  logic              pc_en, sp_en, hold_en, dlat_en;

  // Next-state values and clock enables
  always_comb begin
    pc_d    = pc_q;   pc_en   = 1'b0;
    sp_d    = sp_q;   sp_en   = 1'b0;
    hold_d  = hold_q; hold_en = 1'b0;
    dlat_d  = dlat_q; dlat_en = 1'b0;
    unique case (step_i)
      ST_FETCH: begin
        pc_d = pc_q + PC_ONE; pc_en = 1'b1;
      end
      ST_C_LO: begin
        pc_d   = pc_q + PC_ONE; pc_en   = 1'b1;
        dlat_d = rdata_i;       dlat_en = 1'b1;
      end
      ST_C_STK: begin
        sp_d   = dlat_q; sp_en   = 1'b1;
        hold_d = sp_q;   hold_en = 1'b1;
      end
      ST_C_PSH_H, ST_C_PSH_L: begin
        hold_d = hold_q - SP_ONE; hold_en = 1'b1;
      end
      ST_C_HI: begin
        pc_d = {rdata_i, sp_q}; pc_en = 1'b1;
        sp_d = hold_q;          sp_en = 1'b1;
      end
      ST_R_STK: begin
        sp_d = sp_q + SP_ONE; sp_en = 1'b1;
      end
      ST_R_LO: begin
        dlat_d = rdata_i;       dlat_en = 1'b1;
        sp_d   = sp_q + SP_ONE; sp_en   = 1'b1;
      end
      ST_R_HI: begin
        pc_d = {rdata_i, dlat_q}; pc_en = 1'b1;
      end
      ST_R_END: begin
        pc_d = pc_q + PC_ONE; pc_en = 1'b1;
      end
      default: ;
    endcase
  end

  // Bus drive for the current cycle
  always_comb begin
    addr_o  = pc_q;
    rd_o    = 1'b1;
    wdata_o = '0;
    unique case (step_i)
      ST_C_STK, ST_R_STK, ST_R_LO, ST_R_HI: addr_o = {STACK_PAGE, sp_q};
      ST_C_PSH_H: begin
        addr_o  = {STACK_PAGE, hold_q};
        rd_o    = 1'b0;
        wdata_o = pc_q[ADDR_W-1:DATA_W];
      end
      ST_C_PSH_L: begin
        addr_o  = {STACK_PAGE, hold_q};
        rd_o    = 1'b0;
        wdata_o = pc_q[DATA_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      sp_q   <= RESET_SP;
      hold_q <= '0;
      dlat_q <= '0;
    end else begin
      if (pc_en)   pc_q   <= pc_d;
      if (sp_en)   sp_q   <= sp_d;
      if (hold_en) hold_q <= hold_d;
      if (dlat_en) dlat_q <= dlat_d;
    end
  end

  assign pc_o = pc_q;
  assign sp_o = sp_q;

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int unsigned          DATA_W     = 8,
  parameter int unsigned          ADDR_W     = 2 * DATA_W,
  parameter int unsigned          SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0]    STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0]    CALL_OPC   = 8'h20,
  parameter logic [DATA_W-1:0]    RET_OPC    = 8'h60,
  parameter logic [ADDR_W-1:0]    RESET_PC   = 16'h0200,
  parameter logic [DATA_W-1:0]    RESET_SP   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] sp_o
);

  logic  rst_sync_n;
  step_t step;

  callret_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  callret_ctrl #(
    .DATA_W   (DATA_W),
    .CALL_OPC (CALL_OPC),
    .RET_OPC  (RET_OPC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .opcode_i (bus_rdata_i),
    .step_o   (step),
    .done_o   (done_o)
  );

  callret_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .RESET_PC   (RESET_PC),
    .RESET_SP   (RESET_SP)
  ) u_dpath (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_i  (step),
    .rdata_i (bus_rdata_i),
    .addr_o  (bus_addr_o),
    .rd_o    (bus_rd_o),
    .wdata_o (bus_wdata_o),
    .pc_o    (pc_o),
    .sp_o    (sp_o)
  );

endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk #(
  parameter int unsigned       ADDR_W     = 16,
  parameter int unsigned       DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              done
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  // R4
  push_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_addr[ADDR_W-1:DATA_W] == STACK_PAGE);

  // R11
  push_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && $past(bus_rd)) |=> !bus_rd);

  // R11
  push_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !$past(bus_rd)) |=> bus_rd);

  // R9
  push_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !$past(bus_rd)) |->
      bus_addr[DATA_W-1:0] == $past(bus_addr[DATA_W-1:0]) - ONE);

  // R5
  push_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !$past(bus_rd)) |=>
      bus_addr == {$past(bus_wdata, 2), $past(bus_wdata)});

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind callret_seq callret_seq_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STACK_PAGE (STACK_PAGE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr_o),
  .bus_rd    (bus_rd_o),
  .bus_wdata (bus_wdata_o),
  .done      (done_o)
);

// File: tb/callret_seq_tb.sv
module callret_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 31;

  // {idle, start, addr, rd, wdata, done, sp}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1,1'b1,16'h0200,1'b1,8'h00,1'b0,8'h02},
    {1'b0,1'b0,16'h0200,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0201,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0102,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0102,1'b0,8'h02,1'b0,8'h00},
    {1'b0,1'b0,16'h0101,1'b0,8'h02,1'b0,8'h00},
    {1'b0,1'b0,16'h0202,1'b1,8'h00,1'b1,8'h00},
    {1'b1,1'b1,16'h0400,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0400,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0401,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0100,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0100,1'b0,8'h04,1'b0,8'h00},
    {1'b0,1'b0,16'h01FF,1'b0,8'h02,1'b0,8'h00},
    {1'b0,1'b0,16'h0402,1'b1,8'h00,1'b1,8'h00},
    {1'b1,1'b1,16'h0580,1'b1,8'h00,1'b0,8'hFE},
    {1'b0,1'b0,16'h0580,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0581,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h01FE,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h01FF,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0100,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0402,1'b1,8'h00,1'b1,8'h00},
    {1'b1,1'b1,16'h0403,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0403,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0404,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0100,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0101,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0102,1'b1,8'h00,1'b0,8'h00},
    {1'b0,1'b0,16'h0202,1'b1,8'h00,1'b1,8'h00},
    {1'b1,1'b1,16'h0203,1'b1,8'h00,1'b0,8'h02},
    {1'b0,1'b0,16'h0203,1'b1,8'h00,1'b1,8'h00},
    {1'b1,1'b0,16'h0204,1'b1,8'h00,1'b0,8'h02}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic        rd;
  logic [7:0]  wdata;
  logic        done;
  logic [15:0] pc;
  logic [7:0]  sp;

  logic [7:0]  mem [2048];
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  callret_seq #(.RESET_PC(16'h0200), .RESET_SP(8'h02)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .bus_rdata_i (rdata),
    .bus_addr_o  (addr),
    .bus_rd_o    (rd),
    .bus_wdata_o (wdata),
    .done_o      (done),
    .pc_o        (pc),
    .sp_o        (sp)
  );

  assign rdata = mem[addr[10:0]];

  always @(posedge clk) begin
    if (!rd) mem[addr[10:0]] <= wdata;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=%h expected=%h", 1'b0, 1'b1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    mem[11'h200] = 8'h20; mem[11'h201] = 8'h00; mem[11'h202] = 8'h04;
    mem[11'h400] = 8'h20; mem[11'h401] = 8'h80; mem[11'h402] = 8'h05;
    mem[11'h580] = 8'h60;
    mem[11'h403] = 8'h60;
    mem[11'h203] = 8'hEA;

    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 values while held in reset
    chk("R1 rd in reset", {15'd0, rd}, 16'd1);
    chk("R1 done in reset", {15'd0, done}, 16'd0);
    chk("R1 pc in reset", pc, 16'h0200);
    chk("R1 sp in reset", {8'd0, sp}, 16'h0002);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 addr after reset", addr, 16'h0200);

    // Main vector walk: nested call/return with stack wrap
    for (int r = 0; r < NVEC; r++) begin
      logic [35:0] v;
      string       at;
      v = VEC[r];
      if (r > 0) @(negedge clk);
      start = v[34];
      #1;
      if (r >= 10 && r <= 19)      at = "R9";
      else if (r < 14)             at = "R3";
      else if (r < 28)             at = "R7";
      else                         at = "R2";
      chk($sformatf("%s addr row %0d", at, r), addr, v[33:18]);
      chk($sformatf("R11 rd row %0d", r), {15'd0, rd}, {15'd0, v[17]});
      chk($sformatf("R6 done row %0d", r), {15'd0, done}, {15'd0, v[8]});
      if (!v[17]) chk($sformatf("R4 wdata row %0d", r), {8'd0, wdata}, {8'd0, v[16:9]});
      if (v[35]) begin
        at = (r == 7 || r == 14) ? "R6" : "R8";
        chk($sformatf("%s pc row %0d", at, r), pc, v[33:18]);
        chk($sformatf("%s sp row %0d", at, r), {8'd0, sp}, {8'd0, v[7:0]});
      end
    end
    start = 1'b0;

    // R5: stored return addresses are call address plus two
    chk("R5 outer push", {mem[11'h102], mem[11'h101]}, 16'h0202);
    chk("R5 inner push", {mem[11'h100], mem[11'h1FF]}, 16'h0402);

    // Reset back to the start for the directed cases
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pc after re-reset", pc, 16'h0200);
    chk("R1 sp after re-reset", {8'd0, sp}, 16'h0002);

    // R10: start held high throughout a call
    start = 1'b1;
    for (int k = 0; k < 6; k++) @(negedge clk);
    #1;
    chk("R10 done on cycle 6", {15'd0, done}, 16'd1);
    start = 1'b0;
    @(negedge clk);
    #1;
    chk("R10 pc after call", pc, 16'h0400);
    chk("R10 sp after call", {8'd0, sp}, 16'h0000);
    @(negedge clk);
    #1;
    chk("R10 no extra instruction", addr, 16'h0400);
    chk("R10 done stays low", {15'd0, done}, 16'd0);

    // R1: asynchronous reset during a push cycle
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R4 push cycle write", {15'd0, rd}, 16'd0);
    chk("R9 push at page bottom", addr, 16'h0100);
    rst_n = 1'b0;
    #1;
    chk("R1 async rd", {15'd0, rd}, 16'd1);
    chk("R1 async addr", addr, 16'h0200);
    chk("R1 async sp", {8'd0, sp}, 16'h0002);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule